// File: doc/BRIEF.md
# FIFO Status and Interrupt Unit

This block watches the transmit and receive FIFOs of a serial controller from the outside. It takes the occupancy level of each FIFO, the push and pop strobes, and a busy flag from the shifter. From these it builds a 5-bit status word, a 5-bit raw interrupt vector, a masked interrupt vector, a single interrupt line and one DMA request for each direction. The FIFO storage and the serial shifting sit outside the block.

Configuration arrives over a small write port that is selected by a 4-bit code. That port loads the interrupt thresholds, the interrupt mask, the DMA enables and the DMA trigger levels. The same port also carries a write-one-to-clear command for the sticky error bits. A registered read port returns any configuration register, the status word, the interrupt vectors or the two occupancy levels.

The block also gates the strobes. A push into a full TX FIFO and a pop from an empty RX FIFO are refused. Each refusal raises a sticky error bit, so the FIFO drops the pushed word and the popped data reads as zero.

Top module: `fis_status_irq`

## Requirements
- R1: While reset is high, and at the first sample after reset is released, the status word, the raw and masked interrupt vectors, irq, both DMA requests and rd_data are all zero. The thresholds, mask, DMA enables and DMA levels also clear to zero.
- R2: One clock after the levels are presented, status holds: bit0 = busy_in, bit1 = TX level equals DEPTH, bit2 = TX level is zero, bit3 = RX level is zero, bit4 = RX level equals DEPTH.
- R3: Bits 0 and 4 of the raw interrupt vector follow the levels, with one clock of latency. Bit0 is set while the TX level is at or below the TX threshold. Bit4 is set while the RX level is at or above the RX threshold.
- R4: The following strobes are refused (tx_accept or rx_accept low in the same cycle) and each sets a raw bit one clock later. A push at TX level DEPTH sets bit1. A pop at RX level zero sets bit2. An RX push at RX level DEPTH sets bit3. These three bits stay set until they are cleared.
- R5: A write with select 3 clears sticky bits. Data bit0 clears all three. Data bit1 clears RX underflow, bit2 clears RX overflow and bit3 clears TX overflow. If an error event and its clear fall in the same cycle, the event wins.
- R6: masked_irq is the raw vector ANDed with the mask (select 2), using the same bit layout. irq is high exactly when masked_irq is nonzero.
- R7: The TX threshold (select 0) and RX threshold (select 1) accept only values from 0 to DEPTH-1. A write of DEPTH or more leaves the old value in place.
- R8: With DMA control (select 4) bit1 set, tx_dma_req is high while the TX level is at or below the TX DMA level (select 5). With bit0 set, rx_dma_req is high while the RX level is above the RX DMA level (select 6). Each request has one clock of latency. The DMA levels have the same range rule as R7.
- R9: rd_data is valid one clock after rd_sel. Selects 0 to 6 return the configuration registers (select 3 reads zero). Select 7 returns status, 8 the raw vector, 9 the masked vector, 10 the TX level and 11 the RX level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| busy_in | input | 1 | Shifter busy flag |
| tx_level | input | LVL_W | TX FIFO occupancy |
| rx_level | input | LVL_W | RX FIFO occupancy |
| tx_push | input | 1 | TX FIFO write strobe |
| rx_push | input | 1 | RX FIFO write strobe from the shifter |
| rx_pop | input | 1 | RX FIFO read strobe |
| tx_accept | output | 1 | Push is allowed into the TX FIFO |
| rx_accept | output | 1 | Pop returns real RX data |
| cfg_we | input | 1 | Configuration write enable |
| cfg_sel | input | 4 | Register select code |
| cfg_wdata | input | DATA_W | Write data |
| rd_sel | input | 4 | Read select code |
| rd_data | output | DATA_W | Registered read data |
| status | output | 5 | Status word |
| raw_irq | output | 5 | Raw interrupt vector |
| masked_irq | output | 5 | Masked interrupt vector |
| irq | output | 1 | Combined interrupt |
| tx_dma_req | output | 1 | TX DMA request |
| rx_dma_req | output | 1 | RX DMA request |

## Verification
The hardest case to reach is an error event and its clear landing in the same clock. The bench holds rx_pop high at an empty RX level for exactly the cycle in which the clear write is latched, then reads the raw vector back to confirm that underflow survived. Threshold writes at and just past the legal range are read back through the read port. Those reads go into a scoreboard queue that checks each one in the cycle its data becomes valid.

// File: rtl/fis_pkg.sv
package fis_pkg;
  localparam int ST_BUSY = 0;
  localparam int ST_TXF  = 1;
  localparam int ST_TXE  = 2;
  localparam int ST_RXE  = 3;
  localparam int ST_RXF  = 4;

  localparam int IR_TXTH = 0;
  localparam int IR_TXOV = 1;
  localparam int IR_RXUN = 2;
  localparam int IR_RXOV = 3;
  localparam int IR_RXTH = 4;

  localparam int CL_ALL  = 0;
  localparam int CL_RXUN = 1;
  localparam int CL_RXOV = 2;
  localparam int CL_TXOV = 3;

  localparam int DC_RX = 0;
  localparam int DC_TX = 1;

  typedef enum logic [3:0] {
    SEL_TX_THR  = 4'd0,
    SEL_RX_THR  = 4'd1,
    SEL_MASK    = 4'd2,
    SEL_CLEAR   = 4'd3,
    SEL_DMA_CTL = 4'd4,
    SEL_TX_DMA  = 4'd5,
    SEL_RX_DMA  = 4'd6,
    SEL_STATUS  = 4'd7,
    SEL_RAW     = 4'd8,
    SEL_MASKED  = 4'd9,
    SEL_TX_LVL  = 4'd10,
    SEL_RX_LVL  = 4'd11
  } fis_sel_e;
endpackage

// File: rtl/fis_cfg_regs.sv
module fis_cfg_regs
  import fis_pkg::*;
#(
  parameter int DEPTH  = 16,
  parameter int DATA_W = 8,
  parameter int TH_W   = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  fis_sel_e          cfg_sel,
  input  logic [DATA_W-1:0] cfg_wdata,
  output logic [TH_W-1:0]   tx_thr,
  output logic [TH_W-1:0]   rx_thr,
  output logic [TH_W-1:0]   tx_dma_lvl,
  output logic [TH_W-1:0]   rx_dma_lvl,
  output logic [4:0]        mask,
  output logic [1:0]        dma_en,
  output logic [3:0]        clr_vec
);
  localparam int NLVL = 4;

  logic [TH_W-1:0] lvl_q [NLVL];
  logic            in_range;

  assign in_range = int'(cfg_wdata) < DEPTH;

  for (genvar g = 0; g < NLVL; g++) begin : g_lvl
    localparam fis_sel_e SEL_G = (g == 0) ? SEL_TX_THR :
                                 (g == 1) ? SEL_RX_THR :
                                 (g == 2) ? SEL_TX_DMA : SEL_RX_DMA;
    always_ff @(posedge clk) begin
      if (rst) begin
        lvl_q[g] <= '0;
      end else if (cfg_we && cfg_sel == SEL_G && in_range) begin
        lvl_q[g] <= cfg_wdata[TH_W-1:0];
      end
    end

    // R7 / R8: an out-of-range value never replaces the stored level
    a_r7_range_hold: assert property (@(posedge clk) disable iff (rst)
      (cfg_we && cfg_sel == SEL_G && !in_range) |=> $stable(lvl_q[g]));
  end

  assign tx_thr     = lvl_q[0];
  assign rx_thr     = lvl_q[1];
  assign tx_dma_lvl = lvl_q[2];
  assign rx_dma_lvl = lvl_q[3];

  always_ff @(posedge clk) begin
    if (rst) begin
      mask   <= '0;
      dma_en <= '0;
    end else if (cfg_we) begin
      if (cfg_sel == SEL_MASK)    mask   <= cfg_wdata[4:0];
      if (cfg_sel == SEL_DMA_CTL) dma_en <= cfg_wdata[1:0];
    end
  end

  assign clr_vec = (cfg_we && cfg_sel == SEL_CLEAR) ? cfg_wdata[3:0] : 4'b0;
endmodule

// File: rtl/fis_irq_core.sv
module fis_irq_core
  import fis_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int LVL_W = $clog2(DEPTH + 1),
  parameter int TH_W  = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             busy_in,
  input  logic [LVL_W-1:0] tx_level,
  input  logic [LVL_W-1:0] rx_level,
  input  logic             tx_push,
  input  logic             rx_push,
  input  logic             rx_pop,
  input  logic [TH_W-1:0]  tx_thr,
  input  logic [TH_W-1:0]  rx_thr,
  input  logic [TH_W-1:0]  tx_dma_lvl,
  input  logic [TH_W-1:0]  rx_dma_lvl,
  input  logic [1:0]       dma_en,
  input  logic [3:0]       clr_vec,
  output logic [4:0]       status_q,
  output logic [4:0]       raw_q,
  output logic             tx_dma_req,
  output logic             rx_dma_req,
  output logic             tx_accept,
  output logic             rx_accept
);
  localparam logic [LVL_W-1:0] FULL = LVL_W'(DEPTH);

  logic tx_full, tx_empty, rx_full, rx_empty;
  logic set_txov, set_rxun, set_rxov;
  logic clr_txov, clr_rxun, clr_rxov;
  logic [4:0] status_n, raw_n;

  assign tx_full  = (tx_level == FULL);
  assign tx_empty = (tx_level == '0);
  assign rx_full  = (rx_level == FULL);
  assign rx_empty = (rx_level == '0);

  assign tx_accept = tx_push && !tx_full;
  assign rx_accept = rx_pop && !rx_empty;

  assign set_txov = tx_push && tx_full;
  assign set_rxun = rx_pop && rx_empty;
  assign set_rxov = rx_push && rx_full;

  assign clr_txov = clr_vec[CL_ALL] || clr_vec[CL_TXOV];
  assign clr_rxun = clr_vec[CL_ALL] || clr_vec[CL_RXUN];
  assign clr_rxov = clr_vec[CL_ALL] || clr_vec[CL_RXOV];

  always_comb begin
    status_n          = '0;
    status_n[ST_BUSY] = busy_in;
    status_n[ST_TXF]  = tx_full;
    status_n[ST_TXE]  = tx_empty;
    status_n[ST_RXE]  = rx_empty;
    status_n[ST_RXF]  = rx_full;

    raw_n          = '0;
    raw_n[IR_TXTH] = tx_level <= LVL_W'(tx_thr);
    raw_n[IR_RXTH] = rx_level >= LVL_W'(rx_thr);
    raw_n[IR_TXOV] = set_txov || (raw_q[IR_TXOV] && !clr_txov);
    raw_n[IR_RXUN] = set_rxun || (raw_q[IR_RXUN] && !clr_rxun);
    raw_n[IR_RXOV] = set_rxov || (raw_q[IR_RXOV] && !clr_rxov);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      status_q   <= '0;
      raw_q      <= '0;
      tx_dma_req <= 1'b0;
      rx_dma_req <= 1'b0;
    end else begin
      status_q   <= status_n;
      raw_q      <= raw_n;
      tx_dma_req <= dma_en[DC_TX] && (tx_level <= LVL_W'(tx_dma_lvl));
      rx_dma_req <= dma_en[DC_RX] && (rx_level >  LVL_W'(rx_dma_lvl));
    end
  end

  // R2: TX full and TX empty never show together
  a_r2_tx_full_empty_excl: assert property (@(posedge clk) disable iff (rst)
    !(status_q[ST_TXF] && status_q[ST_TXE]));

  // R4: a push into a full TX FIFO raises overflow on the next clock
  a_r4_txov_set: assert property (@(posedge clk) disable iff (rst)
    (tx_push && tx_level == FULL) |=> raw_q[IR_TXOV]);

  // R4: overflow stays set while no clear addresses it
  a_r4_txov_sticky: assert property (@(posedge clk) disable iff (rst)
    (raw_q[IR_TXOV] && !clr_vec[CL_ALL] && !clr_vec[CL_TXOV]) |=> raw_q[IR_TXOV]);

  // R8: a DMA request needs its enable on the previous clock
  a_r8_tx_dma_en: assert property (@(posedge clk) disable iff (rst)
    tx_dma_req |-> $past(dma_en[DC_TX]));
endmodule

// File: rtl/fis_status_irq.sv
module fis_status_irq
  import fis_pkg::*;
#(
  parameter int DEPTH  = 16,
  parameter int DATA_W = 8,
  parameter int LVL_W  = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              busy_in,
  input  logic [LVL_W-1:0]  tx_level,
  input  logic [LVL_W-1:0]  rx_level,
  input  logic              tx_push,
  input  logic              rx_push,
  input  logic              rx_pop,
  output logic              tx_accept,
  output logic              rx_accept,
  input  logic              cfg_we,
  input  logic [3:0]        cfg_sel,
  input  logic [DATA_W-1:0] cfg_wdata,
  input  logic [3:0]        rd_sel,
  output logic [DATA_W-1:0] rd_data,
  output logic [4:0]        status,
  output logic [4:0]        raw_irq,
  output logic [4:0]        masked_irq,
  output logic              irq,
  output logic              tx_dma_req,
  output logic              rx_dma_req
);
  localparam int TH_W = $clog2(DEPTH);

  logic [TH_W-1:0] tx_thr, rx_thr, tx_dma_lvl, rx_dma_lvl;
  logic [4:0]      mask;
  logic [1:0]      dma_en;
  logic [3:0]      clr_vec;

  fis_cfg_regs #(.DEPTH(DEPTH), .DATA_W(DATA_W), .TH_W(TH_W)) u_cfg (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_sel(fis_sel_e'(cfg_sel)),
    .cfg_wdata(cfg_wdata), .tx_thr(tx_thr), .rx_thr(rx_thr),
    .tx_dma_lvl(tx_dma_lvl), .rx_dma_lvl(rx_dma_lvl), .mask(mask),
    .dma_en(dma_en), .clr_vec(clr_vec)
  );

  fis_irq_core #(.DEPTH(DEPTH), .LVL_W(LVL_W), .TH_W(TH_W)) u_core (
    .clk(clk), .rst(rst), .busy_in(busy_in), .tx_level(tx_level),
    .rx_level(rx_level), .tx_push(tx_push), .rx_push(rx_push), .rx_pop(rx_pop),
    .tx_thr(tx_thr), .rx_thr(rx_thr), .tx_dma_lvl(tx_dma_lvl),
    .rx_dma_lvl(rx_dma_lvl), .dma_en(dma_en), .clr_vec(clr_vec),
    .status_q(status), .raw_q(raw_irq), .tx_dma_req(tx_dma_req),
    .rx_dma_req(rx_dma_req), .tx_accept(tx_accept), .rx_accept(rx_accept)
  );

  assign masked_irq = raw_irq & mask;
  assign irq        = |masked_irq;

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data <= '0;
    end else begin
      case (fis_sel_e'(rd_sel))
        SEL_TX_THR:  rd_data <= DATA_W'(tx_thr);
        SEL_RX_THR:  rd_data <= DATA_W'(rx_thr);
        SEL_MASK:    rd_data <= DATA_W'(mask);
        SEL_DMA_CTL: rd_data <= DATA_W'(dma_en);
        SEL_TX_DMA:  rd_data <= DATA_W'(tx_dma_lvl);
        SEL_RX_DMA:  rd_data <= DATA_W'(rx_dma_lvl);
        SEL_STATUS:  rd_data <= DATA_W'(status);
        SEL_RAW:     rd_data <= DATA_W'(raw_irq);
        SEL_MASKED:  rd_data <= DATA_W'(masked_irq);
        SEL_TX_LVL:  rd_data <= DATA_W'(tx_level);
        SEL_RX_LVL:  rd_data <= DATA_W'(rx_level);
        default:     rd_data <= '0;
      endcase
    end
  end

  // R9: a status read returns the word that was current one clock earlier
  a_r9_rd_status: assert property (@(posedge clk) disable iff (rst)
    ($past(rd_sel) == 4'(SEL_STATUS)) |-> (rd_data == DATA_W'($past(status))));

  // R6: the interrupt line never rises with an all-zero mask
  a_r6_irq_mask: assert property (@(posedge clk) disable iff (rst)
    (mask == '0) |-> !irq);
endmodule

// File: tb/fis_status_irq_tb_top.sv
module fis_status_irq_tb_top;
  localparam int DEPTH = 16;
  localparam int DATA_W = 8;
  localparam int LVL_W = 5;

  localparam logic [3:0] S_TXTHR = 4'd0, S_RXTHR = 4'd1, S_MASK = 4'd2,
    S_CLR = 4'd3, S_DCTL = 4'd4, S_TXDMA = 4'd5, S_RXDMA = 4'd6,
    S_STAT = 4'd7, S_RAW = 4'd8, S_MSK = 4'd9, S_TXL = 4'd10, S_RXL = 4'd11;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic busy_in = 1'b0;
  logic [LVL_W-1:0] tx_level = '0, rx_level = '0;
  logic tx_push = 1'b0, rx_push = 1'b0, rx_pop = 1'b0;
  logic tx_accept, rx_accept;
  logic cfg_we = 1'b0;
  logic [3:0] cfg_sel = '0, rd_sel = '0;
  logic [DATA_W-1:0] cfg_wdata = '0;
  logic [DATA_W-1:0] rd_data;
  logic [4:0] status, raw_irq, masked_irq;
  logic irq, tx_dma_req, rx_dma_req;

  int checks = 0;
  int failures = 0;
  int cyc = 0;
  bit done = 1'b0;

  typedef struct {int exp; string tag; int cyc;} item_t;
  item_t sb[$];

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  fis_status_irq #(.DEPTH(DEPTH), .DATA_W(DATA_W), .LVL_W(LVL_W)) dut_i (
    .clk(clk), .rst(rst), .busy_in(busy_in), .tx_level(tx_level),
    .rx_level(rx_level), .tx_push(tx_push), .rx_push(rx_push), .rx_pop(rx_pop),
    .tx_accept(tx_accept), .rx_accept(rx_accept), .cfg_we(cfg_we),
    .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata), .rd_sel(rd_sel), .rd_data(rd_data),
    .status(status), .raw_irq(raw_irq), .masked_irq(masked_irq), .irq(irq),
    .tx_dma_req(tx_dma_req), .rx_dma_req(rx_dma_req)
  );

  task automatic chk(input string tag, input int got, input int exp);
    checks++;
    if (got != exp) begin
      failures++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", tag, got, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #2;
  endtask

  task automatic wr(input logic [3:0] sel, input int data);
    cfg_we = 1'b1;
    cfg_sel = sel;
    cfg_wdata = DATA_W'(data);
    step();
    cfg_we = 1'b0;
  endtask

  // driver: pushes the expected read value, the monitor compares it
  task automatic rd(input logic [3:0] sel, input int exp, input string tag);
    item_t it;
    rd_sel = sel;
    it.exp = exp;
    it.tag = tag;
    it.cyc = cyc;
    sb.push_back(it);
    step();
  endtask

  // monitor: read data is valid once a clock edge has passed since issue
  always @(negedge clk) begin
    if (sb.size() > 0 && cyc > sb[0].cyc) begin
      item_t it;
      it = sb.pop_front();
      chk(it.tag, int'(rd_data), it.exp);
    end
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #2;
    rst = 1'b0;
    chk("R1 status", int'(status), 0);
    chk("R1 raw", int'(raw_irq), 0);
    chk("R1 irq", int'(irq), 0);
    chk("R1 dma", int'({tx_dma_req, rx_dma_req}), 0);
    chk("R1 rd_data", int'(rd_data), 0);

    step();
    chk("R2 empty status", int'(status), 'h0C);
    chk("R3 reset thresholds", int'(raw_irq), 'h11);
    rd(S_TXTHR, 0, "R1 tx threshold reset");

    // R7 threshold range
    wr(S_TXTHR, 5);
    wr(S_RXTHR, 10);
    wr(S_TXTHR, 16);
    rd(S_TXTHR, 5, "R7 tx threshold kept");
    wr(S_RXTHR, 15);
    rd(S_RXTHR, 15, "R7 rx threshold max");
    wr(S_RXTHR, 200);
    rd(S_RXTHR, 15, "R7 rx threshold kept");
    wr(S_RXTHR, 10);

    // R3 level-based bits
    tx_level = 5; rx_level = 9;
    step();
    chk("R3 tx at threshold", int'(raw_irq), 'h01);
    tx_level = 6; rx_level = 10;
    step();
    chk("R3 rx at threshold", int'(raw_irq), 'h10);
    chk("R2 mid status", int'(status), 'h00);
    busy_in = 1'b1; tx_level = 16; rx_level = 16;
    step();
    chk("R2 full busy status", int'(status), 'h13);

    // R4 errors
    tx_push = 1'b1;
    #1 chk("R4 tx push refused", int'(tx_accept), 0);
    step();
    tx_push = 1'b0;
    chk("R4 tx overflow", int'(raw_irq), 'h12);
    tx_level = 15; tx_push = 1'b1;
    #1 chk("R4 tx push accepted", int'(tx_accept), 1);
    step();
    tx_push = 1'b0;
    chk("R4 no new error", int'(raw_irq), 'h12);
    rx_level = 0; rx_pop = 1'b1;
    #1 chk("R4 rx pop refused", int'(rx_accept), 0);
    step();
    rx_pop = 1'b0;
    chk("R4 rx underflow", int'(raw_irq), 'h06);
    rx_level = 16; rx_push = 1'b1;
    step();
    rx_push = 1'b0;
    chk("R4 rx overflow", int'(raw_irq), 'h1E);
    rx_level = 5; tx_level = 10;
    step();
    chk("R4 sticky", int'(raw_irq), 'h0E);

    // R5 clears
    wr(S_CLR, 'h04);
    chk("R5 clear rx overflow", int'(raw_irq), 'h06);
    rx_level = 0; rx_pop = 1'b1;
    wr(S_CLR, 'h02);
    rx_pop = 1'b0;
    chk("R5 event beats clear", int'(raw_irq), 'h06);
    wr(S_CLR, 'h01);
    chk("R5 clear all", int'(raw_irq), 'h00);
    rd(S_CLR, 0, "R9 clear reads zero");

    // R6 mask
    tx_level = 16; tx_push = 1'b1;
    step();
    tx_push = 1'b0; tx_level = 10;
    wr(S_MASK, 'h02);
    chk("R6 irq on", int'(irq), 1);
    rd(S_MSK, 'h02, "R6 masked read");
    wr(S_MASK, 'h1D);
    chk("R6 irq off", int'(irq), 0);
    tx_level = 3;
    step();
    chk("R6 masked threshold", int'(masked_irq), 'h01);
    chk("R6 irq threshold", int'(irq), 1);
    wr(S_MASK, 0);
    wr(S_CLR, 'h08);
    chk("R5 clear tx overflow", int'(raw_irq), 'h01);

    // R8 DMA
    wr(S_TXDMA, 4);
    wr(S_RXDMA, 7);
    tx_level = 4; rx_level = 8;
    step();
    chk("R8 disabled", int'({tx_dma_req, rx_dma_req}), 0);
    wr(S_DCTL, 3);
    step();
    chk("R8 both requests", int'({tx_dma_req, rx_dma_req}), 3);
    tx_level = 5; rx_level = 7;
    step();
    chk("R8 past levels", int'({tx_dma_req, rx_dma_req}), 0);
    wr(S_TXDMA, 20);
    rd(S_TXDMA, 4, "R8 dma level kept");
    wr(S_DCTL, 1);
    tx_level = 0; rx_level = 9;
    step();
    chk("R8 rx only", int'({tx_dma_req, rx_dma_req}), 1);

    // R9 reads
    rd(S_DCTL, 1, "R9 dma ctl");
    rd(S_STAT, 'h05, "R9 status");
    rd(S_TXL, 0, "R9 tx level");
    rd(S_RXL, 9, "R9 rx level");
    rd(S_RAW, 'h01, "R9 raw");
    step();
    step();

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule